// File: doc/BRIEF.md
# ATA Task File Register Model

This block models the device side of the ATA register set as a host sees it through a small register bus. The bus has a block select (command block or control block), a 3-bit offset, one-cycle read and write strobes, an 8-bit write byte and a 16-bit read word. The same offset can reach two different registers. Which one is reached depends on whether the access is a read or a write. Examples are error versus features, status versus command, and alternate status versus device control. The block holds the status and error bits, records a pending interrupt and drives an interrupt line that software can mask.

A small stand-in for the medium accepts the read-sector code: it stays busy for a fixed time, then requests a data transfer and serves a sector of 16-bit words. Every other command code ends as an aborted command. A soft reset bit in the control register holds the device busy and restarts it. The model responds only when the device-select bit in the Device register matches its configured device number.

Reads are registered. `rdData` shows the result of a read strobe one cycle after the strobe, and the side effects of that read (interrupt clear, word advance) happen at the same clock edge.

Top module: `ataTaskFile`

## Requirements
- R1: After reset, status reads 0x40 (ready), error reads 0x00, Device reads 0xA0 and `intrq` is low.
- R2: Command-block offsets 2..5 (sector count, LBA low, mid, high) read back the last byte written. A write at offset 1 loads features and leaves the error value read at offset 1 unchanged.
- R3: A Device read (offset 6) returns bits 7 and 5 as 1, and bit 6 (LBA mode), bit 4 (device select) and bits 3..0 (LBA 27..24) as written.
- R4: A write of code 0x20 at offset 7 makes status 0x80 (busy only) until completion, which comes within BUSY_CYC+2 cycles. Status then reads 0x48 (ready, data request) and an interrupt becomes pending.
- R5: While a data request is set, each read of offset 0 returns {LBA low, word index} with the index counting 0..WORDS-1. After the last word, status reads 0x40. A data read with no request returns 0.
- R6: Any other command code completes with status 0x41 (ready, error bit 0) and error 0x04 (abort bit 2). A following command clears the error register.
- R7: A status read (command offset 7) clears the pending interrupt. An alternate-status read (control offset 2) returns the same value and keeps it pending.
- R8: `intrq` is high only when an interrupt is pending and the mask bit (Device Control bit 1) is 0. A pending interrupt survives masking and shows once the mask is cleared.
- R9: While soft reset (Device Control bit 2) is set, status reads 0x80, the error register is 0 and the pending interrupt is cleared. After release, status returns to 0x40 within RESET_CYC+2 cycles.
- R10: While Device bit 4 differs from DEV_ID, every read returns 0 and every write other than Device is ignored.
- R11: While busy, command-block writes are ignored. Device Control writes are still accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 1 | 0 = command block, 1 = control block |
| addr | input | 3 | Register offset within the selected block |
| rdEn | input | 1 | Read strobe, one cycle |
| wrEn | input | 1 | Write strobe, one cycle |
| wrData | input | 8 | Write byte |
| rdData | output | 16 | Registered read result, valid the cycle after rdEn |
| intrq | output | 1 | Interrupt request to the host |

## Verification
The assertions check these properties on every cycle:
- Busy and data request never appear together in the status byte.
- Soft reset always forces busy on the following cycle.
- The mask bit keeps the interrupt line low.
- A status read taken while idle clears the pending interrupt, and an alternate-status read does not.
- Reads addressed to the other device return zero.

Only the bench scenarios can show the remaining behaviour:
- the sector data pattern and its word count;
- the abort path and its error code;
- completion latencies;
- that writes made while busy or while deselected leave no trace once the device is reselected and idle.

// File: rtl/ataTfPkg.sv
package ataTfPkg;
  // status byte bit positions
  localparam int ST_BSY  = 7;
  localparam int ST_DRDY = 6;
  localparam int ST_DRQ  = 3;
  localparam int ST_ERR  = 0;
  // error byte value for an aborted command
  localparam logic [7:0] ERR_ABORT = 8'h04;

  typedef struct packed {
    logic wrTask;    // accepted write at command offsets 1..5
    logic wrDev;     // accepted Device register write
    logic wrDevCtl;  // accepted Device Control write
    logic clrErr;    // new command issued
    logic setAbrt;   // command finished as aborted
    logic rdWord;    // data word read while transfer requested
  } tfStrobe_t;
endpackage

// File: rtl/ataTfCtrl.sv
module ataTfCtrl
  import ataTfPkg::*;
#(
  parameter int BUSY_CYC  = 8,
  parameter int RESET_CYC = 6,
  parameter int WORDS     = 256,
  parameter logic [7:0] READ_CODE = 8'h20,
  localparam int BUSY_W = $clog2(BUSY_CYC + 1),
  localparam int RST_W  = $clog2(RESET_CYC + 1),
  localparam int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regSel,
  input  logic [2:0]       addr,
  input  logic             rdEn,
  input  logic             wrEn,
  input  logic [7:0]       wrByte,
  input  logic             devMatch,
  input  logic             srst,
  input  logic             nIen,
  output tfStrobe_t        stb,
  output logic [7:0]       statusByte,
  output logic [IDX_W-1:0] wordIdx,
  output logic             pending,
  output logic             intrq
);
  logic bsy, drdy, drq, err, isRead;
  logic [BUSY_W-1:0] busyCnt;
  logic [RST_W-1:0]  rstCnt;
  logic cmdWr, goCmd, rdStatus, finish;

  always_comb begin
    cmdWr        = wrEn && !regSel;
    goCmd        = cmdWr && devMatch && !bsy && !srst && (addr == 3'd7);
    rdStatus     = rdEn && !regSel && devMatch && (addr == 3'd7);
    finish       = !srst && (rstCnt == '0) && (busyCnt == BUSY_W'(1));
    stb.wrTask   = cmdWr && devMatch && !bsy && (addr >= 3'd1) && (addr <= 3'd5);
    stb.wrDev    = cmdWr && !bsy && (addr == 3'd6);
    stb.wrDevCtl = wrEn && regSel && devMatch && (addr == 3'd2);
    stb.clrErr   = goCmd;
    stb.setAbrt  = finish && !isRead;
    stb.rdWord   = rdEn && !regSel && devMatch && (addr == 3'd0) && drq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bsy <= 1'b0; drdy <= 1'b1; drq <= 1'b0; err <= 1'b0;
      isRead <= 1'b0; busyCnt <= '0; rstCnt <= '0;
      wordIdx <= '0; pending <= 1'b0;
    end else begin
      if (rdStatus) pending <= 1'b0;
      if (srst) begin
        bsy <= 1'b1; drdy <= 1'b0; drq <= 1'b0; err <= 1'b0;
        pending <= 1'b0; busyCnt <= '0;
        rstCnt <= RST_W'(RESET_CYC);
      end else if (rstCnt != '0) begin
        rstCnt <= rstCnt - RST_W'(1);
        if (rstCnt == RST_W'(1)) begin
          bsy  <= 1'b0;
          drdy <= 1'b1;
        end
      end else if (busyCnt != '0) begin
        busyCnt <= busyCnt - BUSY_W'(1);
        if (finish) begin
          bsy     <= 1'b0;
          drdy    <= 1'b1;
          pending <= 1'b1;
          drq     <= isRead;
          err     <= !isRead;
          wordIdx <= '0;
        end
      end else if (goCmd) begin
        bsy <= 1'b1; drdy <= 1'b0; drq <= 1'b0; err <= 1'b0;
        pending <= 1'b0;
        isRead  <= (wrByte == READ_CODE);
        busyCnt <= BUSY_W'(BUSY_CYC);
      end else if (stb.rdWord) begin
        wordIdx <= wordIdx + IDX_W'(1);
        if (wordIdx == IDX_W'(WORDS - 1)) drq <= 1'b0;
      end
    end
  end

  always_comb begin
    statusByte          = '0;
    statusByte[ST_BSY]  = bsy;
    statusByte[ST_DRDY] = drdy;
    statusByte[ST_DRQ]  = drq;
    statusByte[ST_ERR]  = err;
    intrq               = pending && !nIen;
  end
endmodule

// File: rtl/ataTfData.sv
module ataTfData
  import ataTfPkg::*;
#(
  parameter int DEV_ID = 0,
  parameter int IDX_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regSel,
  input  logic [2:0]       addr,
  input  logic             rdEn,
  input  logic [7:0]       wrByte,
  input  tfStrobe_t        stb,
  input  logic [7:0]       statusByte,
  input  logic [IDX_W-1:0] wordIdx,
  output logic [15:0]      rdData,
  output logic             devMatch,
  output logic             srst,
  output logic             nIen
);
  logic [7:0] features, secCnt, lbaLo, lbaMid, lbaHi, errReg;
  logic       lbaMode, devBit;
  logic [3:0] lbaTop;
  logic [15:0] rdNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      features <= '0; secCnt <= '0; lbaLo <= '0; lbaMid <= '0; lbaHi <= '0;
      lbaMode <= 1'b0; devBit <= 1'b0; lbaTop <= '0;
    end else begin
      if (stb.wrTask) begin
        case (addr)
          3'd1:    features <= wrByte;
          3'd2:    secCnt   <= wrByte;
          3'd3:    lbaLo    <= wrByte;
          3'd4:    lbaMid   <= wrByte;
          default: lbaHi    <= wrByte;
        endcase
      end
      if (stb.wrDev) begin
        lbaMode <= wrByte[6];
        devBit  <= wrByte[4];
        lbaTop  <= wrByte[3:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srst <= 1'b0; nIen <= 1'b0; errReg <= '0;
    end else begin
      if (stb.wrDevCtl) begin
        srst <= wrByte[2];
        nIen <= wrByte[1];
      end
      if (srst || stb.clrErr) errReg <= '0;
      else if (stb.setAbrt)   errReg <= ERR_ABORT;
    end
  end

  assign devMatch = (devBit == DEV_ID[0]);

  always_comb begin
    rdNext = '0;
    if (devMatch) begin
      if (!regSel) begin
        case (addr)
          3'd0: rdNext = stb.rdWord ? {lbaLo, 8'(wordIdx)} : 16'h0;
          3'd1: rdNext = {8'h0, errReg};
          3'd2: rdNext = {8'h0, secCnt};
          3'd3: rdNext = {8'h0, lbaLo};
          3'd4: rdNext = {8'h0, lbaMid};
          3'd5: rdNext = {8'h0, lbaHi};
          3'd6: rdNext = {8'h0, 1'b1, lbaMode, 1'b1, devBit, lbaTop};
          default: rdNext = {8'h0, statusByte};
        endcase
      end else if (addr == 3'd2) begin
        rdNext = {8'h0, statusByte};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= rdNext;
  end

  logic unusedFeat;
  assign unusedFeat = ^features;
endmodule

// File: rtl/ataTaskFile.sv
module ataTaskFile
  import ataTfPkg::*;
#(
  parameter int DEV_ID    = 0,
  parameter int BUSY_CYC  = 8,
  parameter int RESET_CYC = 6,
  parameter int WORDS     = 256,
  parameter logic [7:0] READ_CODE = 8'h20,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regSel,
  input  logic [2:0]  addr,
  input  logic        rdEn,
  input  logic        wrEn,
  input  logic [7:0]  wrData,
  output logic [15:0] rdData,
  output logic        intrq
);
  tfStrobe_t        stb;
  logic [7:0]       statusByte;
  logic [IDX_W-1:0] wordIdx;
  logic             devMatch, srst, nIen, pending;

  ataTfCtrl #(
    .BUSY_CYC(BUSY_CYC), .RESET_CYC(RESET_CYC),
    .WORDS(WORDS), .READ_CODE(READ_CODE)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .addr(addr),
    .rdEn(rdEn), .wrEn(wrEn), .wrByte(wrData),
    .devMatch(devMatch), .srst(srst), .nIen(nIen),
    .stb(stb), .statusByte(statusByte), .wordIdx(wordIdx),
    .pending(pending), .intrq(intrq)
  );

  ataTfData #(.DEV_ID(DEV_ID), .IDX_W(IDX_W)) uData (
    .clk(clk), .rstN(rstN), .regSel(regSel), .addr(addr),
    .rdEn(rdEn), .wrByte(wrData), .stb(stb),
    .statusByte(statusByte), .wordIdx(wordIdx),
    .rdData(rdData), .devMatch(devMatch), .srst(srst), .nIen(nIen)
  );
endmodule

// File: rtl/ataTfChecker.sv
module ataTfChecker (
  input logic        clk,
  input logic        rstN,
  input logic        regSel,
  input logic [2:0]  addr,
  input logic        rdEn,
  input logic        wrEn,
  input logic [15:0] rdData,
  input logic        intrq,
  input logic [7:0]  statusByte,
  input logic        devMatch,
  input logic        srst,
  input logic        nIen,
  input logic        pending
);
  a_r4_bsy_excludes_drq: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[7] |-> !statusByte[3]);

  a_r9_srst_forces_busy: assert property (@(posedge clk) disable iff (!rstN)
    srst |=> statusByte[7]);

  a_r8_mask_blocks_irq: assert property (@(posedge clk) disable iff (!rstN)
    nIen |-> !intrq);

  a_r7_status_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !regSel && addr == 3'd7 && devMatch && !statusByte[7]) |=> !pending);

  a_r7_alt_read_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && regSel && addr == 3'd2 && pending && !srst) |=> pending);

  a_r10_foreign_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !devMatch) |=> (rdData == 16'h0));
endmodule

bind ataTaskFile ataTfChecker uChk (.*);

// File: tb/sim_ataTaskFile.sv
`timescale 1ns/1ps
module sim_ataTaskFile;
  localparam int BUSY_CYC  = 8;
  localparam int RESET_CYC = 6;
  localparam int WORDS     = 256;

  logic clk = 1'b0, rstN = 1'b0, regSel = 1'b0, rdEn = 1'b0, wrEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [15:0] rdData;
  logic intrq;
  int nChecks = 0, nFails = 0;

  always #5 clk = ~clk;

  ataTaskFile #(.DEV_ID(0), .BUSY_CYC(BUSY_CYC), .RESET_CYC(RESET_CYC),
                .WORDS(WORDS), .READ_CODE(8'h20)) u0 (
    .clk(clk), .rstN(rstN), .regSel(regSel), .addr(addr), .rdEn(rdEn),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .intrq(intrq));

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wrReg(input logic sel, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); regSel = sel; addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic sel, input logic [2:0] a, output logic [15:0] v);
    @(negedge clk); regSel = sel; addr = a; rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0; v = rdData;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pollIdle(output logic [15:0] v, output int n);
    n = 0;
    do begin rdReg(1'b1, 3'd2, v); n++; end while (v[7] && n < 500);
  endtask

  task automatic testReset();
    logic [15:0] v;
    rdReg(0, 3'd7, v); check("R1 status", v, 16'h0040);
    rdReg(0, 3'd1, v); check("R1 error", v, 16'h0000);
    rdReg(0, 3'd6, v); check("R1 device", v, 16'h00A0);
    check("R1 intrq", {15'h0, intrq}, 16'h0);
  endtask

  task automatic testTaskRegs();
    logic [15:0] v;
    wrReg(0, 3'd2, 8'h12); wrReg(0, 3'd3, 8'h3C);
    wrReg(0, 3'd4, 8'h56); wrReg(0, 3'd5, 8'h78);
    wrReg(0, 3'd1, 8'hFF);
    rdReg(0, 3'd2, v); check("R2 sector count", v, 16'h0012);
    rdReg(0, 3'd3, v); check("R2 lba low", v, 16'h003C);
    rdReg(0, 3'd4, v); check("R2 lba mid", v, 16'h0056);
    rdReg(0, 3'd5, v); check("R2 lba high", v, 16'h0078);
    rdReg(0, 3'd1, v); check("R2 features not error", v, 16'h0000);
    wrReg(0, 3'd6, 8'h4A);
    rdReg(0, 3'd6, v); check("R3 device fixed bits", v, 16'h00EA);
  endtask

  task automatic testReadCmd();
    logic [15:0] v; int n;
    wrReg(0, 3'd7, 8'h20);
    rdReg(1, 3'd2, v); check("R4 busy status", v, 16'h0080);
    pollIdle(v, n);
    check("R4 done status", v, 16'h0048);
    check("R4 latency bound", 16'(n <= BUSY_CYC + 2), 16'h1);
    check("R4 intrq pending", {15'h0, intrq}, 16'h1);
    rdReg(1, 3'd2, v); check("R7 alt status", v, 16'h0048);
    check("R7 alt keeps intrq", {15'h0, intrq}, 16'h1);
    rdReg(0, 3'd7, v); check("R7 status value", v, 16'h0048);
    check("R7 status clears intrq", {15'h0, intrq}, 16'h0);
    for (int i = 0; i < WORDS; i++) begin
      rdReg(0, 3'd0, v);
      check("R5 data word", v, {8'h3C, 8'(i)});
    end
    rdReg(0, 3'd7, v); check("R5 status after sector", v, 16'h0040);
    rdReg(0, 3'd0, v); check("R5 data without request", v, 16'h0000);
  endtask

  task automatic testAbortMask();
    logic [15:0] v; int n;
    wrReg(1, 3'd2, 8'h02);
    wrReg(0, 3'd7, 8'h99);
    pollIdle(v, n);
    check("R6 abort status", v, 16'h0041);
    check("R8 masked intrq", {15'h0, intrq}, 16'h0);
    rdReg(0, 3'd1, v); check("R6 abort error", v, 16'h0004);
    wrReg(1, 3'd2, 8'h00);
    check("R8 unmask shows pending", {15'h0, intrq}, 16'h1);
    rdReg(0, 3'd7, v);
    check("R7 clear after unmask", {15'h0, intrq}, 16'h0);
    wrReg(0, 3'd7, 8'h20);
    pollIdle(v, n);
    rdReg(0, 3'd1, v); check("R6 error cleared by new command", v, 16'h0000);
  endtask

  task automatic testBusyWrite();
    logic [15:0] v; int n;
    wrReg(0, 3'd7, 8'h99);
    wrReg(0, 3'd3, 8'h77);
    pollIdle(v, n);
    rdReg(0, 3'd3, v); check("R11 lba low kept while busy", v, 16'h003C);
    rdReg(0, 3'd7, v); check("R11 status after abort", v, 16'h0041);
  endtask

  task automatic testSoftReset();
    logic [15:0] v; int n;
    wrReg(0, 3'd7, 8'h99);
    pollIdle(v, n);
    check("R9 pending before reset", {15'h0, intrq}, 16'h1);
    wrReg(1, 3'd2, 8'h04);
    idle(1);
    rdReg(1, 3'd2, v); check("R9 status in reset", v, 16'h0080);
    check("R9 intrq cleared", {15'h0, intrq}, 16'h0);
    rdReg(0, 3'd1, v); check("R9 error cleared", v, 16'h0000);
    wrReg(1, 3'd2, 8'h00);
    pollIdle(v, n);
    check("R9 status after release", v, 16'h0040);
    check("R9 release latency bound", 16'(n <= RESET_CYC + 2), 16'h1);
  endtask

  task automatic testForeign();
    logic [15:0] v;
    wrReg(0, 3'd6, 8'h10);
    rdReg(0, 3'd7, v); check("R10 foreign status", v, 16'h0000);
    rdReg(1, 3'd2, v); check("R10 foreign alt status", v, 16'h0000);
    rdReg(0, 3'd3, v); check("R10 foreign lba low", v, 16'h0000);
    wrReg(0, 3'd3, 8'h55);
    wrReg(0, 3'd7, 8'h20);
    wrReg(0, 3'd6, 8'h00);
    rdReg(0, 3'd3, v); check("R10 lba low untouched", v, 16'h003C);
    rdReg(0, 3'd7, v); check("R10 no command started", v, 16'h0040);
    check("R10 no interrupt", {15'h0, intrq}, 16'h0);
  endtask

  initial begin
    idle(4);
    rstN = 1'b1;
    idle(2);
    testReset();
    testTaskRegs();
    testReadCmd();
    testAbortMask();
    testBusyWrite();
    testSoftReset();
    testForeign();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #2000000;
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule